// File: doc/BRIEF.md
# Per-Crossing Trigger Bit Prescaler

This block thins a vector of trigger decision bits. Each bit has its own prescale down-counter, and there is a separate set of these counters for each bunch-crossing slot in the event window. When a bit fires, its counter decrements. The bit reaches the output only on the firing that brings the counter to zero, and at that point the counter reloads from the bit's prescale factor. A signed crossing offset picks the slot: zero selects the centre of the window, and negative offsets select earlier slots.

Counters take their start values from the factor input in two cases: on the first event after reset, and on every luminosity-segment start pulse. A global bypass flag lets every fired bit through without touching any counter. A readout clear empties the registered output word but leaves the counters alone. The result is registered and appears one cycle after the event.

Top module: `trig_prescaler`

## Requirements
- R1: While reset is held, out_valid_o and out_bits_o are 0 at every clock.
- R2: out_valid_o goes high exactly one cycle after a cycle with evt_valid_i high and rd_clr_i low, and is low otherwise.
- R3: For a bit with a factor F of 2 or more, and with counters freshly loaded for the addressed slot, the bit appears at the output on the F-th, 2F-th, 3F-th (and so on) firing in that slot. On every other firing the output bit is 0.
- R4: An input bit that is low in an event outputs 0 and leaves all of its counters unchanged.
- R5: A bit whose factor is 1 passes unchanged, and its counters are not modified.
- R6: A bit whose factor is 0 never passes unless bypass is set. Its counters are not modified.
- R7: With bypass_i high, every fired bit passes unchanged and no counter changes.
- R8: The slot index is N_SLOTS/2 plus evt_ofs_i, read as a signed two's-complement value, so offsets -2..2 select slots 0..4 for five slots. Each slot has its own counters. An event whose index falls outside 0..N_SLOTS-1 outputs all zeros and touches no counter.
- R9: The first event after reset loads every counter in every slot from factors_i (bit k uses bits [16k+15:16k]). That event counts as the first firing.
- R10: seg_start_i reloads every counter from the factors. When it coincides with an event, the reload wins: prescaled bits of that event output 0 and are not decremented, while bits with factor 1 or with bypass still pass.
- R11: rd_clr_i forces out_valid_o and out_bits_o to 0 in the next cycle. The counters still evolve exactly as the same-cycle event dictates, as if no clear had been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid_i | input | 1 | A decision vector is presented this cycle |
| evt_bits_i | input | N_BITS | Raw trigger decision bits |
| evt_ofs_i | input | OFS_W | Signed crossing offset within the event window |
| factors_i | input | N_BITS*FACT_W | Prescale factor per bit, bit k in slice k |
| bypass_i | input | 1 | Pass all fired bits without prescaling |
| seg_start_i | input | 1 | Luminosity-segment start: reload all counters |
| rd_clr_i | input | 1 | Clear the registered output word |
| out_valid_o | output | 1 | Output word valid |
| out_bits_o | output | N_BITS | Prescaled decision bits |

## Verification
The bench targets five corner cases:

- **Interleaved slots.** Offsets are interleaved so that each slot's firing sequence is counted separately. A design that shared counters across slots would let bits through at the wrong firings.
- **Out-of-window offsets.** Offsets of -4, -3 and 3 fall outside the window. A design that wrapped or clipped the index would either pass these bits or corrupt a neighbouring slot's counter.
- **Segment start colliding with an event.** A design that decremented in that cycle would let its next pass through one firing early.
- **Readout clears in mid-sequence.** A design that reset counters on a clear would restart the count.
- **Factor 0 and factor 1 bits, and the first-event load.** These sit next to ordinary bits. A design that skipped the first-event load would hold a zero count and pass the first firing.

// File: rtl/trig_prescaler_pkg.sv
// Shared helpers for the trigger prescaler.
// Assumes the crossing offset is a signed value centred on the window middle.
package trig_prescaler_pkg;

    // Width needed to index n entries, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Map a signed crossing offset to a counter-slot index.
    function automatic int slot_of(input int ofs, input int n_slots);
        return (n_slots / 2) + ofs;
    endfunction

endpackage

// File: rtl/psc_slot_map.sv
// Converts the signed crossing offset into a slot index and a range flag.
// Assumes: the offset is two's complement; out-of-range gives slot 0 and in_range_o low.
module psc_slot_map
    import trig_prescaler_pkg::*;
#(
    parameter int N_SLOTS = 5,
    parameter int OFS_W   = 3,
    parameter int SLOT_W  = idx_width(N_SLOTS)
) (
    input  logic signed [OFS_W-1:0]  ofs_i,
    output logic        [SLOT_W-1:0] slot_o,
    output logic                     in_range_o
);

    int raw_slot;

    // Compute the raw index and check that it lies inside the window.
    always_comb begin
        raw_slot   = slot_of(int'(ofs_i), N_SLOTS);
        in_range_o = (raw_slot >= 0) && (raw_slot < N_SLOTS);
        slot_o     = in_range_o ? SLOT_W'(raw_slot) : '0;
    end

endmodule

// File: rtl/psc_bit_lane.sv
// One trigger bit: holds one down-counter per crossing slot and decides pass/drop.
// Assumes: evt_i is already qualified by the range check; load_all_i reloads every
// slot, and seg_i (segment start) blocks the decrement in the same cycle.
module psc_bit_lane #(
    parameter int N_SLOTS = 5,
    parameter int FACT_W  = 16,
    parameter int SLOT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              bit_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [FACT_W-1:0] factor_i,
    input  logic              bypass_i,
    input  logic              seg_i,
    input  logic              load_all_i,
    input  logic              primed_i,
    output logic              pass_o
);

    logic [FACT_W-1:0] cnt_q [N_SLOTS];
    logic [FACT_W-1:0] sel_cnt;
    logic [FACT_W-1:0] nxt_cnt;
    logic              hit;
    logic              is_unity;
    logic              is_zero;
    logic              upd;
    logic              at_end;

    // Decide pass/drop and the new counter value for the addressed slot.
    always_comb begin
        sel_cnt  = primed_i ? cnt_q[slot_i] : factor_i;
        hit      = evt_i && bit_i;
        is_unity = (factor_i == FACT_W'(1));
        is_zero  = (factor_i == '0);
        at_end   = (sel_cnt <= FACT_W'(1));
        nxt_cnt  = at_end ? factor_i : (sel_cnt - FACT_W'(1));
        upd      = hit && !bypass_i && !is_unity && !is_zero && !seg_i;
        if (!hit)                     pass_o = 1'b0;
        else if (bypass_i || is_unity) pass_o = 1'b1;
        else if (is_zero || seg_i)    pass_o = 1'b0;
        else                          pass_o = at_end;
    end

    // Counter storage: bulk reload, or single-slot decrement/reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SLOTS; s++) cnt_q[s] <= '0;
        end else if (load_all_i) begin
            for (int s = 0; s < N_SLOTS; s++)
                cnt_q[s] <= (upd && (SLOT_W'(s) == slot_i)) ? nxt_cnt : factor_i;
        end else if (upd) begin
            cnt_q[slot_i] <= nxt_cnt;
        end
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_chk
        // R4: with no firing and no reload, the counter holds.
        assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!(evt_i && bit_i) && !load_all_i) |=> $stable(cnt_q[s]));
        // R10: segment start leaves every counter at the factor.
        assert_seg_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
            seg_i |=> (cnt_q[s] == $past(factor_i)));
        // R7: bypass with no reload leaves counters untouched.
        assert_bypass_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bypass_i && !load_all_i) |=> $stable(cnt_q[s]));
    end

endmodule

// File: rtl/trig_prescaler.sv
// Top: prescales a trigger decision vector per bit and per crossing slot.
// Assumes: factors are stable while used; a result appears one cycle after its event.
module trig_prescaler
    import trig_prescaler_pkg::*;
#(
    parameter int N_BITS  = 8,
    parameter int N_SLOTS = 5,
    parameter int FACT_W  = 16,
    parameter int OFS_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     evt_valid_i,
    input  logic [N_BITS-1:0]        evt_bits_i,
    input  logic signed [OFS_W-1:0]  evt_ofs_i,
    input  logic [N_BITS*FACT_W-1:0] factors_i,
    input  logic                     bypass_i,
    input  logic                     seg_start_i,
    input  logic                     rd_clr_i,
    output logic                     out_valid_o,
    output logic [N_BITS-1:0]        out_bits_o
);

    localparam int SLOT_W = idx_width(N_SLOTS);

    logic [SLOT_W-1:0] slot;
    logic              in_range;
    logic              primed_q;
    logic              load_all;
    logic              lane_evt;
    logic [N_BITS-1:0] pass_vec;

    psc_slot_map #(
        .N_SLOTS (N_SLOTS),
        .OFS_W   (OFS_W),
        .SLOT_W  (SLOT_W)
    ) u_map (
        .ofs_i      (evt_ofs_i),
        .slot_o     (slot),
        .in_range_o (in_range)
    );

    // Qualify the event and form the bulk-reload strobe.
    always_comb begin
        lane_evt = evt_valid_i && in_range;
        load_all = seg_start_i || (evt_valid_i && !primed_q);
    end

    // Remember that the counters have been loaded once since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                           primed_q <= 1'b0;
        else if (evt_valid_i || seg_start_i)  primed_q <= 1'b1;
    end

    for (genvar b = 0; b < N_BITS; b++) begin : g_lane
        psc_bit_lane #(
            .N_SLOTS (N_SLOTS),
            .FACT_W  (FACT_W),
            .SLOT_W  (SLOT_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (lane_evt),
            .bit_i      (evt_bits_i[b]),
            .slot_i     (slot),
            .factor_i   (factors_i[b*FACT_W +: FACT_W]),
            .bypass_i   (bypass_i),
            .seg_i      (seg_start_i),
            .load_all_i (load_all),
            .primed_i   (primed_q),
            .pass_o     (pass_vec[b])
        );
    end

    // Output register with readout clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_clr_i) begin
            out_valid_o <= 1'b0;
            out_bits_o  <= '0;
        end else begin
            out_valid_o <= evt_valid_i;
            out_bits_o  <= evt_valid_i ? pass_vec : '0;
        end
    end

    // R2: one-cycle latency of the valid flag.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && !rd_clr_i) |=> out_valid_o);
    // R11: a clear empties the output word.
    assert_clear_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> (!out_valid_o && (out_bits_o == '0)));
    // R3: an output bit is never set unless its input bit was set.
    assert_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((out_bits_o & ~$past(evt_bits_i)) == '0));
    // R7: bypass with an in-window event copies the input bits.
    assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && in_range && bypass_i && !rd_clr_i) |=> (out_bits_o == $past(evt_bits_i)));
    // R8: an out-of-window event yields an empty word.
    assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && !in_range) |=> (out_bits_o == '0));

endmodule

// File: tb/sim_trig_prescaler.sv
`timescale 1ns/1ps
module sim_trig_prescaler;

    localparam int NB = 8;
    localparam int NS = 5;
    localparam int FW = 16;
    localparam int OW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_valid = 1'b0;
    logic [NB-1:0]     evt_bits = '0;
    logic [OW-1:0]     evt_ofs = '0;
    logic [NB*FW-1:0]  factors = '0;
    logic              bypass = 1'b0;
    logic              seg_start = 1'b0;
    logic              rd_clr = 1'b0;
    logic              out_valid;
    logic [NB-1:0]     out_bits;

    int checks = 0;
    int errors = 0;
    int fac [NB];
    int mcnt [NB][NS];
    bit mprimed = 1'b0;

    always #2.5 clk = ~clk;

    trig_prescaler #(.N_BITS(NB), .N_SLOTS(NS), .FACT_W(FW), .OFS_W(OW)) u0 (
        .clk (clk), .rst_n (rst_n), .evt_valid_i (evt_valid), .evt_bits_i (evt_bits),
        .evt_ofs_i (evt_ofs), .factors_i (factors), .bypass_i (bypass),
        .seg_start_i (seg_start), .rd_clr_i (rd_clr),
        .out_valid_o (out_valid), .out_bits_o (out_bits)
    );

    task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One event cycle: drive, advance the reference model, compare after the edge.
    task automatic step(input string tag, input bit v, input logic [NB-1:0] b,
                        input int ofs, input bit byp, input bit seg, input bit clr);
        logic [NB-1:0] eb;
        bit ev;
        bit load;
        int sl;
        bit inr;
        @(negedge clk);
        evt_valid = v; evt_bits = b; evt_ofs = OW'(ofs);
        bypass = byp; seg_start = seg; rd_clr = clr;
        sl = NS / 2 + ofs;
        inr = (sl >= 0) && (sl < NS);
        load = seg || (v && !mprimed);
        eb = '0;
        for (int i = 0; i < NB; i++) begin
            int f;
            int c;
            int newc;
            f = fac[i];
            newc = -1;
            if (v && inr && b[i]) begin
                if (byp || f == 1) eb[i] = 1'b1;
                else if (f == 0 || seg) eb[i] = 1'b0;
                else begin
                    c = mprimed ? mcnt[i][sl] : f;
                    if (c <= 1) begin eb[i] = 1'b1; newc = f; end
                    else newc = c - 1;
                end
            end
            if (load) for (int s = 0; s < NS; s++) mcnt[i][s] = f;
            if (newc >= 0) mcnt[i][sl] = newc;
        end
        if (v || seg) mprimed = 1'b1;
        ev = v && !clr;
        if (clr || !v) eb = '0;
        @(posedge clk);
        #1;
        chk({tag, " R2 valid"}, NB'(out_valid), NB'(ev));
        chk(tag, out_bits, eb);
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fac = '{3, 1, 0, 2, 5, 4, 2, 7};
        for (int i = 0; i < NB; i++) factors[i*FW +: FW] = FW'(fac[i]);
        evt_bits = '1;
        evt_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", NB'(out_valid), '0);
        chk("R1 reset bits", out_bits, '0);
        @(negedge clk);
        rst_n = 1'b1; evt_valid = 1'b0; evt_bits = '0;

        // First event primes; factor sequences on centre slot.
        for (int k = 0; k < 12; k++) step("R3 R5 R6 R9 centre", 1, '1, 0, 0, 0, 0);
        // Low bits leave counters alone.
        step("R4 zero bits", 1, '0, 0, 0, 0, 0);
        step("R4 partial", 1, 8'h0F, 0, 0, 0, 0);
        step("R4 idle", 0, '1, 0, 0, 0, 0);
        // Interleaved slots and out-of-window offsets.
        for (int k = 0; k < 10; k++) begin
            step("R8 slot lo", 1, '1, -2, 0, 0, 0);
            step("R8 slot hi", 1, '1, 2, 0, 0, 0);
            step("R8 out hi", 1, '1, 3, 0, 0, 0);
            step("R8 out lo", 1, '1, -3, 0, 0, 0);
            step("R8 out min", 1, '1, -4, 0, 0, 0);
        end
        // Bypass.
        for (int k = 0; k < 4; k++) step("R7 bypass", 1, 8'hA5 ^ 8'(k), 1, 1, 0, 0);
        step("R7 after bypass", 1, '1, 1, 0, 0, 0);
        // Segment start alone and colliding with an event.
        step("R10 seg alone", 0, '0, 0, 0, 1, 0);
        step("R10 seg+evt", 1, '1, 0, 0, 1, 0);
        step("R10 seg+bypass", 1, '1, -1, 1, 1, 0);
        for (int k = 0; k < 8; k++) step("R10 after seg", 1, '1, 0, 0, 0, 0);
        // Readout clears mid-sequence.
        step("R11 clear", 1, '1, 0, 0, 0, 1);
        step("R11 clear idle", 0, '0, 0, 0, 0, 1);
        for (int k = 0; k < 6; k++) step("R11 after clear", 1, '1, 0, 0, 0, 0);
        // Mixed traffic.
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step("R3 mixed", r < 85, 8'($urandom), int'($urandom_range(0, 7)) - 4,
                 r == 3, r == 7 || r == 50, r == 11);
        end
        @(negedge clk);
        evt_valid = 1'b0; seg_start = 1'b0; rd_clr = 1'b0; bypass = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule